// File: doc/BRIEF.md
# Two-Pole Two-Zero Voltage-Loop Compensator

This block closes a sampled voltage loop in fixed point. When the converter front end signals that a fresh output-voltage sample is ready, the block forms the loop error (reference minus measurement) and evaluates a second-order difference equation. The equation uses the present error, the two previous errors and the two previous outputs. The result is a duty command for a PWM compare register. The command is a Q31 fraction clamped to the range 0 to just under 1, and a one-clock valid strobe marks each new result.

The five coefficients are signed Q26 values driven from outside. A package also provides a default set for a buck stage sampled at 250 kHz. The arithmetic reuses one signed multiplier over five cycles. A controller built as a small state machine sequences the work: ST_IDLE waits for the strobe, ST_MAC performs the five multiply-accumulate steps, and ST_SAT scales, clamps, publishes and shifts the history. The transitions are as follows. ST_IDLE goes to ST_MAC when a start strobe is accepted. ST_MAC goes to ST_SAT after the fifth product. ST_SAT always returns to ST_IDLE. A new command is ready six clocks after the strobe, far inside the half-sample window available before the next PWM period begins.

Top module: `vloop_comp2p2z`

## Requirements
- R1: The error is Vref minus Vsense, both taken as signed 32-bit Q31 values at the rising edge that accepts start_i. The difference is clamped to the range 0x80000000 to 0x7FFFFFFF (signed) instead of wrapping.
- R2: The unclamped result is b0·E(n) + b1·E(n-1) + b2·E(n-2) + a1·U(n-1) + a2·U(n-2). Each coefficient is a signed 32-bit Q26 value. The products are summed without loss in a 72-bit accumulator, and the sum is then shifted right arithmetically by 26 bits, rounding toward minus infinity.
- R3: duty_o is the R2 result clamped to 0 when it is negative and to 0x7FFFFFFF when it exceeds that value.
- R4: duty_valid_o is high for exactly one clock per accepted start. It rises on the sixth rising edge after the edge that accepts start_i. duty_o changes only on that edge and holds its value otherwise.
- R5: On each completed sample the history shifts. E(n) becomes E(n-1) and the old E(n-1) becomes E(n-2). The clamped output becomes U(n-1) and the old U(n-1) becomes U(n-2).
- R6: A start_i sampled while a sample is in progress (from the accepting edge up to and including the edge that raises duty_valid_o) is ignored. It produces no extra pulse and does not change the result.
- R7: An active-low rst_n clears duty_o, duty_valid_o and all four history values to zero.
- R8: The package default coefficients equal round(x·2^26) for a1 = 1.605, a2 = -0.605, b0 = -12.34, b1 = -22.53 and b2 = 10.28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion-done strobe; starts one sample |
| vsense_i | input | 32 | Measured output voltage, signed Q31 |
| vref_i | input | 32 | Voltage reference, signed Q31 |
| coef_a1_i | input | 32 | Output tap 1 coefficient, signed Q26 |
| coef_a2_i | input | 32 | Output tap 2 coefficient, signed Q26 |
| coef_b0_i | input | 32 | Error tap 0 coefficient, signed Q26 |
| coef_b1_i | input | 32 | Error tap 1 coefficient, signed Q26 |
| coef_b2_i | input | 32 | Error tap 2 coefficient, signed Q26 |
| duty_o | output | 32 | Duty command, Q31, 0 to 0x7FFFFFFF |
| duty_valid_o | output | 1 | One-clock strobe on a new duty_o |

## Verification
The bound checker watches several properties on every cycle: the single-cycle valid pulse, the exact six-edge latency, that duty_o holds between pulses and never goes negative, that no pulse appears without an accepted start, and that the history registers take the published output and the shifted error at the moment of each pulse. Only the bench scenarios can show arithmetic correctness. They compare against an independent model the value produced under the default coefficients, the clamping of the error subtraction at both ends, clamping of the output, the effect of single-tap coefficient sets that expose each history position, that a start arriving mid-computation is ignored, that a mid-run reset clears the history, and the default coefficient encodings.

// File: rtl/vloop_comp_pkg.sv
`timescale 1ns/1ps
package vloop_comp_pkg;

    localparam int unsigned SIG_W     = 32;
    localparam int unsigned COEF_W    = 32;
    localparam int unsigned COEF_FRAC = 26;
    localparam int unsigned GUARD_W   = 8;
    localparam int unsigned ACC_W     = SIG_W + COEF_W + GUARD_W;
    localparam int unsigned NTAP      = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MAC  = 2'd1,
        ST_SAT  = 2'd2
    } comp_state_e;

    // Default loop coefficients, signed Q26 (x * 2^26, rounded)
    localparam logic signed [COEF_W-1:0] DEF_A1 =  32'sd107709727;
    localparam logic signed [COEF_W-1:0] DEF_A2 = -32'sd40600863;
    localparam logic signed [COEF_W-1:0] DEF_B0 = -32'sd828123382;
    localparam logic signed [COEF_W-1:0] DEF_B1 = -32'sd1511962706;
    localparam logic signed [COEF_W-1:0] DEF_B2 =  32'sd689879122;

endpackage

// File: rtl/vloop_err_sub.sv
`timescale 1ns/1ps
module vloop_err_sub #(
    parameter int unsigned W = 32
) (
    input  logic signed [W-1:0] minuend_i,
    input  logic signed [W-1:0] subtrahend_i,
    output logic signed [W-1:0] diff_o
);

    localparam logic signed [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0] wide_diff;

    always_comb begin
        wide_diff = {minuend_i[W-1], minuend_i} - {subtrahend_i[W-1], subtrahend_i};
        if (wide_diff[W] != wide_diff[W-1]) begin
            diff_o = wide_diff[W] ? NEG_LIM : POS_LIM;
        end else begin
            diff_o = wide_diff[W-1:0];
        end
    end

endmodule

// File: rtl/vloop_mac.sv
`timescale 1ns/1ps
module vloop_mac #(
    parameter int unsigned CW = 32,
    parameter int unsigned SW = 32,
    parameter int unsigned AW = 72
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 en_i,
    input  logic signed [CW-1:0] coef_i,
    input  logic signed [SW-1:0] opnd_i,
    output logic signed [AW-1:0] acc_o
);

    localparam int unsigned PW  = CW + SW;
    localparam int unsigned EXT = AW - PW;

    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_ext;

    always_comb begin
        prod     = coef_i * opnd_i;
        prod_ext = {{EXT{prod[PW-1]}}, prod};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_o <= '0;
        end else if (clr_i) begin
            acc_o <= '0;
        end else if (en_i) begin
            acc_o <= acc_o + prod_ext;
        end
    end

endmodule

// File: rtl/vloop_hist.sv
`timescale 1ns/1ps
module vloop_hist #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_i,
    input  logic [W-1:0]       din_i,
    output logic [DEPTH*W-1:0] taps_o
);

    logic [W-1:0] stage [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage[g] <= '0;
            end else if (shift_i) begin
                if (g == 0) begin
                    stage[g] <= din_i;
                end else begin
                    stage[g] <= stage[(g == 0) ? 0 : g-1];
                end
            end
        end
        assign taps_o[g*W +: W] = stage[g];
    end

endmodule

// File: rtl/vloop_ctrl.sv
`timescale 1ns/1ps
module vloop_ctrl
    import vloop_comp_pkg::*;
#(
    parameter int unsigned TAPS = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    output logic                     cap_o,
    output logic                     acc_clr_o,
    output logic                     acc_en_o,
    output logic                     fin_o,
    output logic [$clog2(TAPS)-1:0]  tap_o
);

    localparam int unsigned IW = $clog2(TAPS);
    localparam logic [IW-1:0] LAST_TAP = IW'(TAPS - 1);

    comp_state_e state, state_nxt;
    logic [IW-1:0] tap_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // tap index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_q <= '0;
        end else if (state == ST_MAC) begin
            tap_q <= tap_q + 1'b1;
        end else begin
            tap_q <= '0;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (start_i) state_nxt = ST_MAC;
            ST_MAC:  if (tap_q == LAST_TAP) state_nxt = ST_SAT;
            ST_SAT:  state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cap_o     = 1'b0;
        acc_clr_o = 1'b0;
        acc_en_o  = 1'b0;
        fin_o     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cap_o     = start_i;
                acc_clr_o = start_i;
            end
            ST_MAC:  acc_en_o = 1'b1;
            ST_SAT:  fin_o    = 1'b1;
            default: ;
        endcase
    end

    assign tap_o = tap_q;

endmodule

// File: rtl/vloop_comp2p2z.sv
`timescale 1ns/1ps
module vloop_comp2p2z
    import vloop_comp_pkg::*;
#(
    parameter int unsigned SW   = SIG_W,
    parameter int unsigned CW   = COEF_W,
    parameter int unsigned FRAC = COEF_FRAC,
    parameter int unsigned GW   = GUARD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [31:0]   vsense_i,
    input  logic [31:0]   vref_i,
    input  logic [31:0]   coef_a1_i,
    input  logic [31:0]   coef_a2_i,
    input  logic [31:0]   coef_b0_i,
    input  logic [31:0]   coef_b1_i,
    input  logic [31:0]   coef_b2_i,
    output logic [31:0]   duty_o,
    output logic          duty_valid_o
);

    localparam int unsigned AW    = SW + CW + GW;
    localparam int unsigned TAPS  = NTAP;
    localparam int unsigned IW    = $clog2(TAPS);
    localparam int unsigned HDEP  = 2;
    localparam logic [SW-1:0] DUTY_MAX = {1'b0, {(SW-1){1'b1}}};

    logic          cap, acc_clr, acc_en, fin;
    logic [IW-1:0] tap;

    logic signed [SW-1:0] err_now, err_cur;
    logic [HDEP*SW-1:0]   e_taps, u_taps;
    logic signed [SW-1:0] e_tap1, e_tap2, u_tap1, u_tap2;

    logic signed [CW-1:0] sel_coef;
    logic signed [SW-1:0] sel_opnd;
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] acc_scaled;
    logic [SW-1:0]        duty_nxt;

    vloop_ctrl #(.TAPS(TAPS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .cap_o     (cap),
        .acc_clr_o (acc_clr),
        .acc_en_o  (acc_en),
        .fin_o     (fin),
        .tap_o     (tap)
    );

    vloop_err_sub #(.W(SW)) u_err (
        .minuend_i    (vref_i),
        .subtrahend_i (vsense_i),
        .diff_o       (err_now)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_cur <= '0;
        end else if (cap) begin
            err_cur <= err_now;
        end
    end

    vloop_hist #(.W(SW), .DEPTH(HDEP)) u_ehist (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (fin),
        .din_i   (err_cur),
        .taps_o  (e_taps)
    );

    vloop_hist #(.W(SW), .DEPTH(HDEP)) u_uhist (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (fin),
        .din_i   (duty_nxt),
        .taps_o  (u_taps)
    );

    assign e_tap1 = e_taps[0 +: SW];
    assign e_tap2 = e_taps[SW +: SW];
    assign u_tap1 = u_taps[0 +: SW];
    assign u_tap2 = u_taps[SW +: SW];

    // operand / coefficient selection for the shared multiplier
    always_comb begin
        unique case (tap)
            IW'(0): begin sel_coef = coef_b0_i; sel_opnd = err_cur; end
            IW'(1): begin sel_coef = coef_b1_i; sel_opnd = e_tap1;  end
            IW'(2): begin sel_coef = coef_b2_i; sel_opnd = e_tap2;  end
            IW'(3): begin sel_coef = coef_a1_i; sel_opnd = u_tap1;  end
            IW'(4): begin sel_coef = coef_a2_i; sel_opnd = u_tap2;  end
            default: begin sel_coef = '0; sel_opnd = '0; end
        endcase
    end

    vloop_mac #(.CW(CW), .SW(SW), .AW(AW)) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (acc_clr),
        .en_i   (acc_en),
        .coef_i (sel_coef),
        .opnd_i (sel_opnd),
        .acc_o  (acc)
    );

    // rescale Q57 sum to Q31 and clamp to the duty range
    always_comb begin
        acc_scaled = acc >>> FRAC;
        if (acc_scaled[AW-1]) begin
            duty_nxt = '0;
        end else if (|acc_scaled[AW-2:SW-1]) begin
            duty_nxt = DUTY_MAX;
        end else begin
            duty_nxt = acc_scaled[SW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_o       <= '0;
            duty_valid_o <= 1'b0;
        end else begin
            duty_valid_o <= fin;
            if (fin) begin
                duty_o <= duty_nxt;
            end
        end
    end

endmodule

// File: rtl/vloop_comp2p2z_chk.sv
`timescale 1ns/1ps
module vloop_comp2p2z_chk #(
    parameter int unsigned W   = 32,
    parameter int unsigned LAT = 6
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [W-1:0] duty_o,
    input logic         duty_valid_o,
    input logic [W-1:0] e_tap1,
    input logic [W-1:0] e_tap2,
    input logic [W-1:0] u_tap1
);

    logic       pend;
    logic [7:0] cnt;
    logic       busy, accept;

    assign busy   = pend && !duty_valid_o;
    assign accept = start_i && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
            cnt  <= '0;
        end else if (accept) begin
            pend <= 1'b1;
            cnt  <= '0;
        end else if (duty_valid_o) begin
            pend <= 1'b0;
        end else if (pend && cnt != 8'hFF) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        duty_valid_o |=> !duty_valid_o);

    p_latency_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        duty_valid_o |-> (cnt == 8'(LAT)));

    p_latency_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> (cnt <= 8'(LAT)));

    p_duty_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !duty_valid_o |-> $stable(duty_o));

    p_duty_nonneg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        duty_o[W-1] == 1'b0);

    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        duty_valid_o |-> pend);

    p_uhist_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        duty_valid_o |-> (u_tap1 == duty_o));

    p_ehist_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        duty_valid_o |-> (e_tap2 == $past(e_tap1)));

    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> (duty_o == '0 && !duty_valid_o));

endmodule

bind vloop_comp2p2z vloop_comp2p2z_chk #(.W(32), .LAT(6)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .duty_o       (duty_o),
    .duty_valid_o (duty_valid_o),
    .e_tap1       (e_tap1),
    .e_tap2       (e_tap2),
    .u_tap1       (u_tap1)
);

// File: tb/vloop_comp2p2z_test.sv
`timescale 1ns/1ps
module vloop_comp2p2z_test;
    import vloop_comp_pkg::*;

    localparam int NVEC = 8;
    localparam int EXP_LAT = 7;  // edges counted including the accepting edge
    localparam logic signed [31:0] ONE_Q26 = 32'sd67108864;

    // stimulus table: {vref, vsense}
    localparam logic [63:0] VEC [NVEC] = '{
        {32'h66666666, 32'h66666666},
        {32'h66666666, 32'h60000000},
        {32'h66666666, 32'h6A000000},
        {32'h66666666, 32'h66600000},
        {32'h66666666, 32'h70000000},
        {32'h66666666, 32'h50000000},
        {32'h66666666, 32'h66666000},
        {32'h66666666, 32'h66670000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [31:0] vref = '0, vs = '0;
    logic signed [31:0] ca1 = DEF_A1, ca2 = DEF_A2, cb0 = DEF_B0, cb1 = DEF_B1, cb2 = DEF_B2;
    logic [31:0] duty;
    logic        dv;

    int checks = 0;
    int errors = 0;

    logic signed [31:0] me1 = '0, me2 = '0, mu1 = '0, mu2 = '0;

    always #2.5 clk = ~clk;

    vloop_comp2p2z uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .vsense_i     (vs),
        .vref_i       (vref),
        .coef_a1_i    (ca1),
        .coef_a2_i    (ca2),
        .coef_b0_i    (cb0),
        .coef_b1_i    (cb1),
        .coef_b2_i    (cb2),
        .duty_o       (duty),
        .duty_valid_o (dv)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic model_clear();
        me1 = '0; me2 = '0; mu1 = '0; mu2 = '0;
    endtask

    task automatic model_step(input logic signed [31:0] r, input logic signed [31:0] s,
                              output logic [31:0] u);
        logic signed [32:0] d;
        logic signed [31:0] e;
        logic signed [71:0] acc;
        logic signed [71:0] sh;
        d = {r[31], r} - {s[31], s};
        if (d > 33'sd2147483647)       e = 32'sh7FFFFFFF;
        else if (d < -33'sd2147483648) e = 32'sh80000000;
        else                           e = d[31:0];
        acc = cb0 * e + cb1 * me1 + cb2 * me2 + ca1 * mu1 + ca2 * mu2;
        sh = acc >>> 26;
        if (sh < 0)                      u = 32'h0;
        else if (sh > 72'sd2147483647)   u = 32'h7FFFFFFF;
        else                             u = sh[31:0];
        me2 = me1; me1 = e; mu2 = mu1; mu1 = u;
    endtask

    // one sample: drive at a falling edge, wait for the strobe, check value and timing
    task automatic run_sample(input logic [31:0] r, input logic [31:0] s, input string req);
        logic [31:0] exp;
        int n;
        model_step(r, s, exp);
        vref = r; vs = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!dv && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk({req, " duty"}, duty, exp);
        chk("R4 latency", 32'(n), 32'(EXP_LAT));
        @(negedge clk);
        chk("R4 single pulse", {31'b0, dv}, 32'h0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int pulses;
        logic [31:0] exp_a;
        logic [31:0] dummy;

        // R7 reset state
        repeat (3) @(negedge clk);
        chk("R7 reset duty", duty, 32'h0);
        chk("R7 reset valid", {31'b0, dv}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 default coefficient encodings
        chk("R8 a1", DEF_A1, int'(1.605 * 67108864.0));
        chk("R8 a2", DEF_A2, int'(-0.605 * 67108864.0));
        chk("R8 b0", DEF_B0, int'(-12.34 * 67108864.0));
        chk("R8 b1", DEF_B1, int'(-22.53 * 67108864.0));
        chk("R8 b2", DEF_B2, int'(10.28 * 67108864.0));

        // R2 default-coefficient table walk
        for (int i = 0; i < NVEC; i++) begin
            run_sample(VEC[i][63:32], VEC[i][31:0], "R2 table");
        end

        // R1 error formation with b0 = 1.0, all else 0
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        model_clear();
        ca1 = '0; ca2 = '0; cb1 = '0; cb2 = '0; cb0 = ONE_Q26;
        run_sample(32'h40000000, 32'h10000000, "R1 plain difference");
        // R1 positive clamp exposed with b0 = 0.25
        cb0 = ONE_Q26 >>> 2;
        run_sample(32'h7FFFFFFF, 32'h80000000, "R1 positive clamp");
        // R1/R3 negative clamp drives output to 0
        cb0 = ONE_Q26;
        run_sample(32'h80000000, 32'h7FFFFFFF, "R1 R3 negative clamp");
        // R3 upper clamp: gain 8 on a large error
        cb0 = ONE_Q26 <<< 3;
        run_sample(32'h60000000, 32'h10000000, "R3 upper clamp");

        // R5 history positions: single-tap coefficient sets
        cb0 = '0; cb1 = ONE_Q26;
        run_sample(32'h20000000, 32'h00000000, "R5 e1 tap a");
        run_sample(32'h31000000, 32'h00000000, "R5 e1 tap b");
        cb1 = '0; cb2 = ONE_Q26;
        run_sample(32'h05000000, 32'h00000000, "R5 e2 tap");
        cb2 = '0; cb0 = ONE_Q26 >>> 1; ca1 = ONE_Q26;
        run_sample(32'h10000000, 32'h00000000, "R5 u1 tap");
        cb0 = '0; ca1 = '0; ca2 = ONE_Q26 >>> 1;
        run_sample(32'h00000000, 32'h00000000, "R5 u2 tap");

        // R6 start during computation is ignored
        cb0 = ONE_Q26; ca2 = '0;
        model_step(32'h22000000, 32'h02000000, exp_a);
        vref = 32'h22000000; vs = 32'h02000000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        pulses = 0;
        @(negedge clk);
        vref = 32'h7F000000; vs = 32'h00000000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 12; k++) begin
            if (dv) begin
                pulses++;
                chk("R6 value unaffected", duty, exp_a);
            end
            @(negedge clk);
        end
        chk("R6 pulse count", 32'(pulses), 32'd1);
        run_sample(32'h11000000, 32'h01000000, "R6 follow-up");

        // R7 mid-run reset clears history
        rst_n = 1'b0;
        @(negedge clk);
        chk("R7 mid reset duty", duty, 32'h0);
        chk("R7 mid reset valid", {31'b0, dv}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        model_clear();
        cb0 = '0; cb1 = ONE_Q26;
        run_sample(32'h30000000, 32'h00000000, "R7 cleared e1");
        ca1 = ONE_Q26; cb1 = '0;
        run_sample(32'h00000000, 32'h00000000, "R7 u1 after clear");
        model_step(32'h0, 32'h0, dummy);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule